// File: doc/BRIEF.md
# Atomic Read-Modify-Write Combine Unit

This unit performs the arithmetic step of an atomic memory instruction. The value already in memory (the "old" value) and a register operand arrive with a 4-bit operation code and a width flag. The unit returns two results. One is the value to write back to memory. The other is the old value, which goes back to the destination register.

Nine combine operations are provided:
- swap
- add
- bitwise AND, OR and XOR
- minimum and maximum, each in a signed and an unsigned form

In word mode only the low half of the 64-bit datapath takes part, and results are sign-extended from bit 31. Operation codes outside the nine set an illegal flag. In that case memory is left unchanged.

Input and output use a valid/ready handshake around a single output register. One operation can be accepted per cycle while the consumer is taking results.

Top module: `amo_alu`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An input taken with in_valid and in_ready both high at a clock edge appears with out_valid high after that edge. out_valid and all output data stay unchanged until out_ready is high at an edge. in_ready equals (not out_valid) or out_ready.
- R3: Op code 0 (swap) gives out_new equal to the register operand.
- R4: Op code 1 (add) gives out_new as old plus operand, wrapping modulo 2^64 in double mode and modulo 2^32 in word mode.
- R5: Op codes 2, 3 and 4 give the bitwise AND, OR and XOR of old and operand.
- R6: Op codes 5 and 6 give the signed minimum and signed maximum of old and operand. In word mode bit 31 is the sign bit.
- R7: Op codes 7 and 8 give the unsigned minimum and unsigned maximum of old and operand.
- R8: out_old always carries the old memory value: unchanged in double mode (in_word=0), and sign-extended from bit 31 in word mode.
- R9: In word mode (in_word=1) bits 63:32 of both inputs are ignored, and out_new is the 32-bit result sign-extended from bit 31.
- R10: Op codes 9 to 15 set out_illegal, and out_new then equals out_old. Legal codes clear out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_word | input | 1 | 1 = 32-bit word mode, 0 = 64-bit |
| in_old | input | 64 | Value read from memory |
| in_src | input | 64 | Register source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_new | output | 64 | Value to store to memory |
| out_old | output | 64 | Value for the destination register |
| out_illegal | output | 1 | Operation code not supported |

## Verification
The hardest cases to reach are word-mode comparisons where the upper halves of the inputs would reverse the result. Examples are a low word with bit 31 set next to a large positive upper half, or garbage in bits 63:32 that would change an unsigned order. The stimulus builds such operand pairs on purpose for every compare op in both widths. These requests are sent while out_ready toggles in a fixed pattern, so results are also held and accepted back to back under stall.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;
  localparam int OPW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;
endpackage

// File: rtl/amo_operand_prep.sv
module amo_operand_prep #(
  parameter int W = 64
) (
  input  logic         word,
  input  logic [W-1:0] raw,
  output logic [W-1:0] prepped
);
  localparam int HALF = W / 2;

  // word mode: drop upper half and sign-extend from the half's top bit
  always_comb begin
    if (word) prepped = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    else      prepped = raw;
  end
endmodule

// File: rtl/amo_combine.sv
module amo_combine
  import amo_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           illegal
);
  logic s_lt, u_lt;

  assign s_lt = $signed(a) < $signed(b);
  assign u_lt = a < b;

  always_comb begin
    illegal = 1'b0;
    case (op)
      OP_SWAP: res = b;
      OP_ADD:  res = a + b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MIN:  res = s_lt ? a : b;
      OP_MAX:  res = s_lt ? b : a;
      OP_MINU: res = u_lt ? a : b;
      OP_MAXU: res = u_lt ? b : a;
      default: begin
        res     = a;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/amo_out_stage.sv
module amo_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         word,
  input  logic [W-1:0] res,
  input  logic [W-1:0] old,
  input  logic         illegal,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_new,
  output logic [W-1:0] out_old,
  output logic         out_illegal
);
  localparam int HALF = W / 2;

  logic         take;
  logic [W-1:0] res_fit;
  logic         word_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign res_fit  = word ? {{HALF{res[HALF-1]}}, res[HALF-1:0]} : res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_new     <= '0;
      out_old     <= '0;
      out_illegal <= 1'b0;
      word_q      <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_new     <= res_fit;
        out_old     <= old;
        out_illegal <= illegal;
        word_q      <= word;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R2: a stalled result keeps its valid and data
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_new) && $stable(out_old) && $stable(out_illegal)));

  // R2: an accepted request shows up on the output next cycle
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9: word-mode results carry sign extension in the upper half
  p_word_sext_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && word_q) |-> (out_new[W-1:HALF] == {HALF{out_new[HALF-1]}}
                               && out_old[W-1:HALF] == {HALF{out_old[HALF-1]}}));
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic            in_word,
  input  logic [XLEN-1:0] in_old,
  input  logic [XLEN-1:0] in_src,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_new,
  output logic [XLEN-1:0] out_old,
  output logic            out_illegal
);
  logic [XLEN-1:0] a_p, b_p, res;
  logic            ill;

  amo_operand_prep #(.W(XLEN)) u_prep_old (.word(in_word), .raw(in_old), .prepped(a_p));
  amo_operand_prep #(.W(XLEN)) u_prep_src (.word(in_word), .raw(in_src), .prepped(b_p));

  amo_combine #(.W(XLEN)) u_comb (
    .op(in_op), .a(a_p), .b(b_p), .res(res), .illegal(ill)
  );

  amo_out_stage #(.W(XLEN)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .word(in_word), .res(res), .old(a_p), .illegal(ill),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_new(out_new), .out_old(out_old), .out_illegal(out_illegal)
  );

  // R10: unsupported op leaves memory value unchanged
  p_illegal_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_new == out_old));

  // R1: a cycle after reset the output stage is empty
  p_reset_empty_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/amo_alu_test.sv
module amo_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_word = 1'b0;
  logic [63:0] in_old = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_new, out_old;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  logic [63:0] q_new[$];
  logic [63:0] q_old[$];
  logic        q_ill[$];
  int          q_req[$];
  int          sent = 0;
  int          got  = 0;
  bit          stall_mode = 1'b0;
  int          rcnt = 0;

  always #2.5 clk = ~clk;

  amo_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_old(in_old), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_new(out_new),
    .out_old(out_old), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // requirement tag number for the op under test
  function automatic int req_of(input logic [3:0] op, input logic w);
    if (op > 8) return 10;
    if (w) return 9;
    case (op)
      0: return 3;
      1: return 4;
      2, 3, 4: return 5;
      5, 6: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic w, input logic [63:0] o, input logic [63:0] s,
                       output logic [63:0] en, output logic [63:0] eo, output logic ei);
    logic [31:0] o3, s3, r3;
    logic [63:0] r6;
    o3 = o[31:0];
    s3 = s[31:0];
    ei = (op > 8);
    if (w) begin
      case (op)
        0: r3 = s3;
        1: r3 = o3 + s3;
        2: r3 = o3 & s3;
        3: r3 = o3 | s3;
        4: r3 = o3 ^ s3;
        5: r3 = ($signed(o3) < $signed(s3)) ? o3 : s3;
        6: r3 = ($signed(o3) > $signed(s3)) ? o3 : s3;
        7: r3 = (o3 < s3) ? o3 : s3;
        8: r3 = (o3 > s3) ? o3 : s3;
        default: r3 = o3;
      endcase
      en = sx(r3);
      eo = sx(o3);
    end else begin
      case (op)
        0: r6 = s;
        1: r6 = o + s;
        2: r6 = o & s;
        3: r6 = o | s;
        4: r6 = o ^ s;
        5: r6 = ($signed(o) < $signed(s)) ? o : s;
        6: r6 = ($signed(o) > $signed(s)) ? o : s;
        7: r6 = (o < s) ? o : s;
        8: r6 = (o > s) ? o : s;
        default: r6 = o;
      endcase
      en = r6;
      eo = o;
    end
  endtask

  task automatic send(input logic [3:0] op, input logic w, input logic [63:0] o, input logic [63:0] s);
    logic [63:0] en, eo;
    logic ei;
    model(op, w, o, s, en, eo, ei);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_word = w; in_old = o; in_src = s;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    q_new.push_back(en); q_old.push_back(eo); q_ill.push_back(ei);
    q_req.push_back(req_of(op, w));
    sent++;
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  // out_ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    rcnt++;
    out_ready = stall_mode ? ((rcnt % 3) == 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #1.5;
    if (!rst && out_valid && out_ready) begin
      logic [63:0] en, eo;
      logic ei;
      int r;
      if (q_new.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected result new=%h expected none", out_new);
      end else begin
        en = q_new.pop_front(); eo = q_old.pop_front();
        ei = q_ill.pop_front(); r = q_req.pop_front();
        got++;
        checks++;
        if (out_new !== en) begin
          fails++;
          $display("FAIL R%0d: out_new actual=%h expected=%h", r, out_new, en);
        end
        checks++;
        if (out_old !== eo) begin
          fails++;
          $display("FAIL R8: out_old actual=%h expected=%h", out_old, eo);
        end
        checks++;
        if (out_illegal !== ei) begin
          fails++;
          $display("FAIL R10: out_illegal actual=%b expected=%b", out_illegal, ei);
        end
      end
    end
  end

  // R2: in_ready must follow the output stage state
  always @(negedge clk) begin
    #1.5;
    if (!rst) begin
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R2: in_ready actual=%b expected=%b", in_ready, (!out_valid || out_ready));
      end
    end
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic batch;
    // R3 swap
    send(0, 0, 64'h1111_2222_3333_4444, 64'hdead_beef_0bad_f00d);
    // R4 add wrap in both widths
    send(1, 0, 64'hffff_ffff_ffff_ffff, 64'h2);
    send(1, 1, 64'h1234_5678_ffff_ffff, 64'h0000_0000_0000_0003);
    send(1, 1, 64'h0000_0000_7fff_ffff, 64'h0000_0000_0000_0001);
    // R5 logic ops
    send(2, 0, 64'hf0f0_f0f0_aaaa_5555, 64'h0ff0_ff00_ffff_0000);
    send(3, 0, 64'hf0f0_0000_aaaa_5555, 64'h0ff0_ff00_0000_0f0f);
    send(4, 1, 64'hffff_0000_8000_00ff, 64'h0000_ffff_0000_ff0f);
    // R6 signed min/max, sign bit 63 vs 31
    send(5, 0, 64'h8000_0000_0000_0000, 64'h1);
    send(6, 0, 64'h8000_0000_0000_0000, 64'h1);
    send(5, 1, 64'h7fff_ffff_8000_0000, 64'h8000_0000_0000_0001);
    send(6, 1, 64'h7fff_ffff_8000_0000, 64'h8000_0000_0000_0001);
    // R7 unsigned min/max
    send(7, 0, 64'h8000_0000_0000_0000, 64'h1);
    send(8, 0, 64'h8000_0000_0000_0000, 64'h1);
    // R9 upper halves that would reverse the unsigned order
    send(7, 1, 64'h0000_0000_ffff_fff0, 64'hffff_ffff_0000_0010);
    send(8, 1, 64'h0000_0000_ffff_fff0, 64'hffff_ffff_0000_0010);
    send(0, 1, 64'h0, 64'h5555_5555_8765_4321);
    // R10 illegal codes
    send(9, 0, 64'hcafe_f00d_1234_5678, 64'h1);
    send(15, 1, 64'hcafe_f00d_9234_5678, 64'h1);
    // R8 old value in double mode with upper bits set
    send(2, 0, 64'hfedc_ba98_7654_3210, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    @(negedge clk);
    #1.5;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid actual=%b expected=0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: in_ready actual=%b expected=1", in_ready);
    end
    batch();
    stall_mode = 1'b1;
    batch();
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    checks++;
    if (got != sent || q_new.size() != 0) begin
      fails++;
      $display("FAIL R2: results actual=%0d expected=%0d", got, sent);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule